// File: doc/BRIEF.md
# Comparator Trip Majority Filter

This block turns the raw one-bit output of an analog comparator into a clean trip signal for a PWM shutdown path. The raw bit can be inverted. It then passes through a synchronizer and is sampled at a programmable fraction of the clock rate. A sliding window holds the most recent samples. The filtered output moves only when enough samples in the window agree. A sticky latch then holds any high filter result until software clears it, or until a PWM period sync pulse clears it when that clear path is enabled.

A two-bit source select picks which version of the signal drives the trip output. The choices are the raw conditioned bit, the synchronized bit, the filter output or the latched filter output. An init pulse restarts sampling and fills the whole window with the present synchronized value, so the filter starts from a known agreement.

Top module: `cmp_trip_filter`

## Requirements
- R1: With `src_sel` = 0, `trip_out` equals `cmp_raw` XOR `cmp_invert` in the same cycle, with no clock involved.
- R2: With `src_sel` = 1, `trip_out` equals `cmp_raw` XOR `cmp_invert` as it was two clock edges earlier.
- R3: A sample is taken on every (`smp_div` + 1)-th clock. The sampling counter restarts from zero on `filt_init`.
- R4: One cycle after `filt_init`, every window entry and the filter output hold the synchronized value that was present at that edge.
- R5: On a sample cycle, the filter output becomes 1 if the ones among the newest `win_len` + 1 samples number at least `agree_min` + 1. Otherwise it becomes 0 if the zeros number at least `agree_min` + 1. Otherwise it holds. The output changes on no other cycle, and `src_sel` = 2 selects it.
- R6: The window spans `win_len` + 1 samples, up to 32. Samples older than the window have no effect on the vote.
- R7: The latch output, selected by `src_sel` = 3, becomes 1 on the edge after the filter output is 1. `lat_clr` clears it to 0, but only when the filter output is 0; a set wins over any clear in the same cycle.
- R8: `pwm_sync` clears the latch only while `sync_clr_en` is 1. With `sync_clr_en` at 0, the latch keeps its value.
- R9: `cmp_invert` = 1 inverts the comparator bit before every later stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmp_raw | input | 1 | Raw comparator output |
| cmp_invert | input | 1 | Invert the comparator bit |
| smp_div | input | PRE_W | Sample divider, period is value + 1 clocks |
| win_len | input | WIN_W | Window size minus one |
| agree_min | input | WIN_W | Required agreement minus one |
| filt_init | input | 1 | Restart the sampler and fill the window |
| lat_clr | input | 1 | Software clear of the latch |
| pwm_sync | input | 1 | PWM period sync pulse |
| sync_clr_en | input | 1 | Allow `pwm_sync` to clear the latch |
| src_sel | input | 2 | Trip source: 0 raw, 1 synced, 2 filtered, 3 latched |
| trip_out | output | 1 | Selected trip signal |

## Verification
Two pairs of functions can land on the same edge. A filter result that sets the latch can meet a software or sync clear. An init pulse can coincide with a sample tick. The bench drives `lat_clr` and `pwm_sync` with the filter held high, and it raises `filt_init` at random against running prescale counts. It judges each edge against a model in which a set beats a clear and init beats a tick. The latched and filtered outputs are read through `src_sel` on the cycle after the collision.

// File: rtl/cmp_trip_pkg.sv
package cmp_trip_pkg;
   typedef enum logic [1:0] {
      SRC_ASYNC = 2'd0,
      SRC_SYNC  = 2'd1,
      SRC_FILT  = 2'd2,
      SRC_LATCH = 2'd3
   } trip_src_e;
endpackage

// File: rtl/cmp_sync.sv
module cmp_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] sh_q;

   if (STAGES < 1) begin : g_bad
      $error("cmp_sync: STAGES must be at least 1");
   end

   if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) sh_q <= '0;
         else        sh_q <= d;
      end
   end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) sh_q <= '0;
         else        sh_q <= {sh_q[STAGES-2:0], d};
      end
   end

   assign q = sh_q[STAGES-1];

   if (STAGES == 2) begin : g_chk2
      logic [1:0] age_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)            age_q <= '0;
         else if (age_q != 2'd2) age_q <= age_q + 2'd1;
      end
      // R2: output lags the input by two edges
      p_sync_lag_r2: assert property (@(posedge clk) disable iff (!rst_n)
         (age_q == 2'd2) |-> (q == $past(d, 2)));
   end
endmodule

// File: rtl/cmp_prescaler.sv
module cmp_prescaler #(
   parameter int PRE_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [PRE_W-1:0] div,
   input  logic             restart,
   output logic             tick
);
   logic [PRE_W-1:0] cnt_q;

   if (PRE_W < 1) begin : g_bad
      $error("cmp_prescaler: PRE_W must be at least 1");
   end

   assign tick = (cnt_q == div);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             cnt_q <= '0;
      else if (restart | tick) cnt_q <= '0;
      else                    cnt_q <= cnt_q + PRE_W'(1);
   end

   // R3: after a tick the next tick follows at once only for a zero divider
   p_tick_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !restart) |=> (tick == (div == '0)));
   // R3: init restarts the count
   p_restart_r3: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> (tick == (div == '0)));
endmodule

// File: rtl/cmp_vote_window.sv
module cmp_vote_window #(
   parameter int WIN_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             din,
   input  logic             tick,
   input  logic             init,
   input  logic [WIN_W-1:0] win_len,
   input  logic [WIN_W-1:0] agree_min,
   output logic             filt_q
);
   localparam int DEPTH = 1 << WIN_W;
   localparam int CNT_W = WIN_W + 1;

   logic [DEPTH-1:0] win_q, win_nx, mask;
   logic [CNT_W-1:0] ones, span, need, zeros;

   if (WIN_W < 1 || WIN_W > 8) begin : g_bad
      $error("cmp_vote_window: WIN_W out of range");
   end

   for (genvar i = 0; i < DEPTH; i++) begin : g_mask
      assign mask[i] = (CNT_W'(i) <= {1'b0, win_len});
   end

   assign win_nx = {win_q[DEPTH-2:0], din};

   always_comb begin
      ones = '0;
      for (int k = 0; k < DEPTH; k++) begin
         ones = ones + CNT_W'(win_nx[k] & mask[k]);
      end
   end

   assign span  = {1'b0, win_len} + CNT_W'(1);
   assign need  = {1'b0, agree_min} + CNT_W'(1);
   assign zeros = span - ones;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         win_q  <= '0;
         filt_q <= 1'b0;
      end else if (init) begin
         win_q  <= {DEPTH{din}};
         filt_q <= din;
      end else if (tick) begin
         win_q <= win_nx;
         if (ones >= need)       filt_q <= 1'b1;
         else if (zeros >= need) filt_q <= 1'b0;
      end
   end

   // R4: init loads the filter with the present input
   p_init_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
      init |=> (filt_q == $past(din)));
   // R5: no change between sample cycles
   p_hold_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !init) |=> $stable(filt_q));
endmodule

// File: rtl/cmp_trip_latch.sv
module cmp_trip_latch (
   input  logic clk,
   input  logic rst_n,
   input  logic set_in,
   input  logic sw_clr,
   input  logic sync_pulse,
   input  logic sync_en,
   output logic lat_q
);
   logic clr;
   assign clr = sw_clr | (sync_pulse & sync_en);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      lat_q <= 1'b0;
      else if (set_in) lat_q <= 1'b1;
      else if (clr)    lat_q <= 1'b0;
   end

   // R7: set wins over any clear
   p_set_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
      set_in |=> lat_q);
   // R8: sync pulse without enable leaves the latch alone
   p_sync_gated_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!set_in && !sw_clr && !sync_en) |=> $stable(lat_q));
   // R8: enabled sync pulse clears
   p_sync_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!set_in && sync_pulse && sync_en) |=> !lat_q);
endmodule

// File: rtl/cmp_trip_filter.sv
module cmp_trip_filter #(
   parameter int PRE_W       = 8,
   parameter int WIN_W       = 5,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmp_raw,
   input  logic             cmp_invert,
   input  logic [PRE_W-1:0] smp_div,
   input  logic [WIN_W-1:0] win_len,
   input  logic [WIN_W-1:0] agree_min,
   input  logic             filt_init,
   input  logic             lat_clr,
   input  logic             pwm_sync,
   input  logic             sync_clr_en,
   input  logic [1:0]       src_sel,
   output logic             trip_out
);
   import cmp_trip_pkg::*;

   logic cond, synced, tick, filt, latched;
   trip_src_e src;

   assign cond = cmp_raw ^ cmp_invert;
   assign src  = trip_src_e'(src_sel);

   cmp_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(cond), .q(synced));

   cmp_prescaler #(.PRE_W(PRE_W)) u_pre (
      .clk(clk), .rst_n(rst_n), .div(smp_div), .restart(filt_init), .tick(tick));

   cmp_vote_window #(.WIN_W(WIN_W)) u_vote (
      .clk(clk), .rst_n(rst_n), .din(synced), .tick(tick), .init(filt_init),
      .win_len(win_len), .agree_min(agree_min), .filt_q(filt));

   cmp_trip_latch u_lat (
      .clk(clk), .rst_n(rst_n), .set_in(filt), .sw_clr(lat_clr),
      .sync_pulse(pwm_sync), .sync_en(sync_clr_en), .lat_q(latched));

   always_comb begin
      unique case (src)
         SRC_ASYNC: trip_out = cond;
         SRC_SYNC:  trip_out = synced;
         SRC_FILT:  trip_out = filt;
         SRC_LATCH: trip_out = latched;
         default:   trip_out = latched;
      endcase
   end

   // R7: a high filter always leaves the latch high
   p_latch_follows_r7: assert property (@(posedge clk) disable iff (!rst_n)
      filt |=> latched);
endmodule

// File: tb/cmp_trip_filter_bench.sv
module cmp_trip_filter_bench;
   localparam int CLK_PERIOD = 10;
   localparam int PRE_W = 8;
   localparam int WIN_W = 5;

   logic clk = 1'b0, rst_n = 1'b0;
   logic cmp_raw = 0, cmp_invert = 0, filt_init = 0, lat_clr = 0, pwm_sync = 0, sync_clr_en = 0;
   logic [PRE_W-1:0] smp_div = '0;
   logic [WIN_W-1:0] win_len = '0, agree_min = '0;
   logic [1:0] src_sel = 2'd0;
   logic trip_out;

   int n_chk = 0, n_bad = 0;

   // reference state
   logic m_s1 = 0, m_s2 = 0, m_filt = 0, m_lat = 0;
   logic [PRE_W-1:0] m_cnt = '0;
   logic [31:0] m_win = '0;

   always #(CLK_PERIOD/2) clk = ~clk;

   cmp_trip_filter #(.PRE_W(PRE_W), .WIN_W(WIN_W)) u_cmp_trip_filter (
      .clk(clk), .rst_n(rst_n), .cmp_raw(cmp_raw), .cmp_invert(cmp_invert),
      .smp_div(smp_div), .win_len(win_len), .agree_min(agree_min),
      .filt_init(filt_init), .lat_clr(lat_clr), .pwm_sync(pwm_sync),
      .sync_clr_en(sync_clr_en), .src_sel(src_sel), .trip_out(trip_out));

   function automatic logic vote(input logic [31:0] w, input int wl, input int th,
                                 input logic cur);
      int ones = 0;
      for (int k = 0; k <= wl; k++) ones += w[k];
      if (ones >= th + 1) return 1'b1;
      if ((wl + 1 - ones) >= th + 1) return 1'b0;
      return cur;
   endfunction

   function automatic logic expect_out();
      case (src_sel)
         2'd0:    return cmp_raw ^ cmp_invert;
         2'd1:    return m_s2;
         2'd2:    return m_filt;
         default: return m_lat;
      endcase
   endfunction

   task automatic check(input string tag);
      logic e;
      e = expect_out();
      n_chk++;
      if (trip_out !== e) begin
         n_bad++;
         $display("FAIL %s sel=%0d actual=%0b expected=%0b t=%0t", tag, src_sel, trip_out, e, $time);
      end
   endtask

   // advance one edge with the reference model, then compare
   task automatic cyc(input string tag);
      logic tk, n_s1, n_s2, n_filt, n_lat;
      logic [PRE_W-1:0] n_cnt;
      logic [31:0] n_win;
      tk    = (m_cnt == smp_div);
      n_s1  = cmp_raw ^ cmp_invert;
      n_s2  = m_s1;
      n_cnt = (filt_init || tk) ? '0 : m_cnt + 1'b1;
      n_win = m_win; n_filt = m_filt;
      if (filt_init) begin
         n_win = {32{m_s2}}; n_filt = m_s2;
      end else if (tk) begin
         n_win  = {m_win[30:0], m_s2};
         n_filt = vote(n_win, int'(win_len), int'(agree_min), m_filt);
      end
      n_lat = m_filt ? 1'b1 : ((lat_clr || (pwm_sync && sync_clr_en)) ? 1'b0 : m_lat);
      @(posedge clk); #1;
      m_s1 = n_s1; m_s2 = n_s2; m_cnt = n_cnt; m_win = n_win; m_filt = n_filt; m_lat = n_lat;
      check(tag);
   endtask

   function automatic string sel_tag();
      case (src_sel)
         2'd0: return "R1";
         2'd1: return "R2";
         2'd2: return "R5";
         default: return "R7";
      endcase
   endfunction

   initial begin
      #(CLK_PERIOD * 200000);
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      void'($urandom(32'h5EED_0042));
      repeat (3) @(posedge clk);
      #1;
      // reset state: filter and latch low (R5, R7)
      src_sel = 2'd2; check("R5");
      src_sel = 2'd3; check("R7");
      rst_n = 1'b1;

      // R9 inversion on the asynchronous path, R1
      src_sel = 2'd0; cmp_invert = 1; cmp_raw = 0; #1 check("R9");
      cmp_raw = 1; #1 check("R1");
      cmp_invert = 0;

      // R2 two-edge lag
      src_sel = 2'd1;
      for (int i = 0; i < 8; i++) begin cmp_raw = i[1]; cyc("R2"); end

      // R4 init fills with present synced value
      cmp_raw = 1; win_len = 5'd7; agree_min = 5'd6; smp_div = 8'd5;
      cyc("R2"); cyc("R2"); cyc("R2");
      src_sel = 2'd2; filt_init = 1; cyc("R4"); filt_init = 0;
      // R4 a single low sample must not flip a filled window
      cmp_raw = 0; cyc("R4"); cmp_raw = 1;
      for (int i = 0; i < 12; i++) cyc("R4");

      // R3 slow sampling; low input needs seven agreeing samples
      cmp_raw = 0; smp_div = 8'd2;
      for (int i = 0; i < 30; i++) cyc("R3");

      // R6 full 32-sample window with unanimous agreement
      win_len = 5'd31; agree_min = 5'd31; smp_div = 8'd0; cmp_raw = 1;
      for (int i = 0; i < 40; i++) cyc("R6");
      cmp_raw = 0; cyc("R6"); cmp_raw = 1;
      for (int i = 0; i < 40; i++) cyc("R6");
      // R6 short window forgets old samples
      win_len = 5'd1; agree_min = 5'd1; cmp_raw = 0;
      for (int i = 0; i < 6; i++) cyc("R6");

      // R7/R8 latch clears: filter is low here, latch is high
      src_sel = 2'd3;
      sync_clr_en = 0; pwm_sync = 1; cyc("R8"); pwm_sync = 0; cyc("R8");
      sync_clr_en = 1; pwm_sync = 1; cyc("R8"); pwm_sync = 0; cyc("R8");
      cmp_raw = 1; for (int i = 0; i < 6; i++) cyc("R7");
      lat_clr = 1; cyc("R7"); cyc("R7"); lat_clr = 0;
      cmp_raw = 0; for (int i = 0; i < 6; i++) cyc("R7");
      lat_clr = 1; cyc("R7"); lat_clr = 0; cyc("R7");

      // constrained random mix
      for (int i = 0; i < 6000; i++) begin
         if (i % 250 == 0) begin
            win_len   = WIN_W'($urandom_range(0, 31));
            agree_min = WIN_W'((int'(win_len) / 2) + $urandom_range(0, int'(win_len) - int'(win_len) / 2));
            smp_div   = PRE_W'($urandom_range(0, 3));
            cmp_invert = 1'($urandom_range(0, 1));
         end
         if ($urandom_range(0, 9) == 0) cmp_raw = ~cmp_raw;
         filt_init   = ($urandom_range(0, 99) == 0);
         lat_clr     = ($urandom_range(0, 19) == 0);
         pwm_sync    = ($urandom_range(0, 9) == 0);
         sync_clr_en = 1'($urandom_range(0, 1));
         src_sel     = 2'($urandom_range(0, 3));
         cyc(sel_tag());
      end
      filt_init = 0; lat_clr = 0; pwm_sync = 0;

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule